// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Cache

This block is the private cache controller that sits between one processor and a shared snooping bus. The cache is direct-mapped and write-through, and it does not allocate on a write miss. The processor side presents one read or write request at a time, each with a word address and a data word. The controller answers a read with the data word and a write with an acknowledge pulse. Every write goes to memory as a single word. Only a read that misses pulls a whole four-word line into the cache.

On the bus side the controller raises a request line, waits for the external arbiter to grant it, and drives one packet while the grant is high. It then waits for the memory reply that carries its own source number. It also watches every packet on the incoming broadcast port. A memory write from any other source that names a line it holds valid clears that line. A processor request that is already queued for the bus is evaluated again when the line it targets is invalidated while it waits.

Top module: `wt_snoop_cache`

## Requirements
- R1: A word address is split as follows. Bits [1:0] select the word within a four-word line. The upper bits form the line address, and its three low bits select one of 8 lines. A lookup hits only when the selected line is valid and its stored tag, which is the full line address, equals the requested line address.
- R2: A read that hits gives `cpu_resp_valid` with the stored word two clock edges after the request is accepted. No bus request or packet is made for it.
- R3: A read that misses raises `bus_req`. Once granted, it drives one packet of type 0 (memory read) with the request address. The read completes when a type 1 (read response) packet with this cache's source number arrives. At that point the whole line is overwritten with the new tag and the four data words (word w in bits [16w+15:16w]), the line is marked valid, and the requested word is returned.
- R4: Every write, hit or miss, drives one packet of type 2 (memory write) carrying the request address and only the one new word. The processor is acknowledged only after a type 3 (write response) packet with this cache's source number arrives.
- R5: On a write hit, the cached word is replaced when the write response arrives. On a write miss, no line is allocated and the cache contents stay as they were.
- R6: An incoming type 2 packet from a different source whose line address matches a valid line clears that line's valid bit. A type 2 packet from this cache's own source number, a packet of another type, or a packet whose tag differs leaves every line unchanged.
- R7: A read or write response that carries a different source number is ignored. It neither completes the pending request nor fills a line.
- R8: If the line targeted by a request that is waiting for a grant is invalidated, `bus_req` is withdrawn for one cycle and the hit/miss outcome is evaluated again. The request then proceeds. A write proceeds as a miss and leaves the cache unchanged.
- R9: Only one request is outstanding at a time. `cpu_busy` is high from the edge that accepts a request until the response or acknowledge appears, and it is low in the cycle of the response.
- R10: `bus_req` is held from the point a packet is needed, through the grant, until the cache's own memory response arrives. A packet is driven only while `bus_gnt` is high.
- R11: Reset clears every valid bit, so the first read after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req_valid | input | 1 | Processor request strobe, taken when not busy |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 12 | Word address |
| cpu_req_wdata | input | 16 | Write data word |
| cpu_busy | output | 1 | Request in progress |
| cpu_resp_valid | output | 1 | One-cycle response or acknowledge |
| cpu_resp_rdata | output | 16 | Read data (zero for a write acknowledge) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_out_valid | output | 1 | Outgoing packet strobe |
| bus_out_type | output | 2 | Packet type: 0 memory read, 2 memory write |
| bus_out_addr | output | 12 | Packet word address |
| bus_out_data | output | 16 | Single write word |
| bus_out_src | output | 3 | This cache's source number |
| bus_in_valid | input | 1 | Incoming broadcast packet strobe |
| bus_in_type | input | 2 | Incoming type: 0 read, 1 read response, 2 write, 3 write response |
| bus_in_addr | input | 12 | Incoming word address |
| bus_in_data | input | 64 | Incoming four-word line |
| bus_in_src | input | 3 | Source number in the incoming packet |

## Verification
The main function is tried with several request patterns. Repeated reads of one line tell a hit from a miss by whether any bus traffic appears. Reads of two line addresses that share one index show that the whole line address is compared. Writes to cached and uncached lines, each followed by a read, separate update-in-place from no-allocate. Foreign and own-source writes, foreign reads, and writes with a different tag, all snooped, show which packets invalidate a line. A foreign write injected while a write waits for its grant must produce the one-cycle drop of the request and a later read miss. Decoy responses with another source number must not end a request.

// File: rtl/wtsc_pkg.sv
package wtsc_pkg;

  typedef enum logic [1:0] {
    PK_MEM_RD  = 2'd0,
    PK_RD_RESP = 2'd1,
    PK_MEM_WR  = 2'd2,
    PK_WR_RESP = 2'd3
  } pkt_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT_GNT,
    ST_WAIT_RESP
  } ctl_state_e;

endpackage

// File: rtl/wtsc_store.sv
module wtsc_store #(
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 10,
  parameter int IDX_W  = $clog2(LINES),
  parameter int WSEL_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        look_idx,
  output logic                    look_valid,
  output logic [TAG_W-1:0]        look_tag,
  output logic [WORDS*DATA_W-1:0] look_data,
  input  logic [IDX_W-1:0]        snp_idx,
  output logic                    snp_valid,
  output logic [TAG_W-1:0]        snp_tag,
  input  logic                    fill_en,
  input  logic [IDX_W-1:0]        fill_idx,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [WORDS*DATA_W-1:0] fill_data,
  input  logic                    upd_en,
  input  logic [IDX_W-1:0]        upd_idx,
  input  logic [WSEL_W-1:0]       upd_sel,
  input  logic [DATA_W-1:0]       upd_word,
  input  logic                    inval_en,
  input  logic [IDX_W-1:0]        inval_idx
);
  localparam int LINE_W = WORDS * DATA_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else begin
        if (inval_en && inval_idx == IDX_W'(g)) valid_q[g] <= 1'b0;
        if (fill_en && fill_idx == IDX_W'(g)) begin
          valid_q[g] <= 1'b1;
          tag_q[g]   <= fill_tag;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[g] <= '0;
      end else if (fill_en && fill_idx == IDX_W'(g)) begin
        data_q[g] <= fill_data;
      end else if (upd_en && upd_idx == IDX_W'(g)) begin
        data_q[g][upd_sel*DATA_W +: DATA_W] <= upd_word;
      end
    end
  end

  assign look_valid = valid_q[look_idx];
  assign look_tag   = tag_q[look_idx];
  assign look_data  = data_q[look_idx];
  assign snp_valid  = valid_q[snp_idx];
  assign snp_tag    = tag_q[snp_idx];

  // R6: a snooped invalidation leaves the line invalid unless a fill lands on it
  a_r6_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_en && !(fill_en && fill_idx == inval_idx)) |=> !valid_q[$past(inval_idx)]);

  // R3: a fill leaves the line valid with the new tag
  a_r3_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag)));

endmodule

// File: rtl/wtsc_snoop.sv
module wtsc_snoop
  import wtsc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int SRC_W  = 3,
  parameter int SRC_ID = 2,
  parameter int IDX_W  = $clog2(LINES),
  parameter int WSEL_W = $clog2(WORDS),
  parameter int QUAD_W = ADDR_W - WSEL_W
) (
  input  logic              bus_in_valid,
  input  logic [1:0]        bus_in_type,
  input  logic [ADDR_W-1:0] bus_in_addr,
  input  logic [SRC_W-1:0]  bus_in_src,
  input  logic              snp_valid,
  input  logic [QUAD_W-1:0] snp_tag,
  output logic [IDX_W-1:0]  snp_idx,
  output logic [QUAD_W-1:0] snp_quad,
  output logic              inval_en,
  output logic              own_rd_resp,
  output logic              own_wr_resp
);
  localparam logic [SRC_W-1:0] MY_SRC = SRC_W'(SRC_ID);

  function automatic logic [QUAD_W-1:0] quad_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WSEL_W];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[WSEL_W +: IDX_W];
  endfunction

  pkt_kind_e kind;
  logic      from_self;
  logic      foreign_wr;

  assign kind        = pkt_kind_e'(bus_in_type);
  assign from_self   = (bus_in_src == MY_SRC);
  assign snp_idx     = idx_of(bus_in_addr);
  assign snp_quad    = quad_of(bus_in_addr);
  assign foreign_wr  = bus_in_valid && kind == PK_MEM_WR && !from_self;
  assign inval_en    = foreign_wr && snp_valid && (snp_tag == snp_quad);
  assign own_rd_resp = bus_in_valid && kind == PK_RD_RESP && from_self;
  assign own_wr_resp = bus_in_valid && kind == PK_WR_RESP && from_self;

endmodule

// File: rtl/wtsc_ctrl.sv
module wtsc_ctrl
  import wtsc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int WORDS  = 4,
  parameter int LINES  = 8,
  parameter int SRC_W  = 3,
  parameter int SRC_ID = 2,
  parameter int IDX_W  = $clog2(LINES),
  parameter int WSEL_W = $clog2(WORDS),
  parameter int QUAD_W = ADDR_W - WSEL_W,
  parameter int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_busy,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_out_valid,
  output logic [1:0]        bus_out_type,
  output logic [ADDR_W-1:0] bus_out_addr,
  output logic [DATA_W-1:0] bus_out_data,
  output logic [SRC_W-1:0]  bus_out_src,
  input  logic [LINE_W-1:0] bus_in_data,
  input  logic              own_rd_resp,
  input  logic              own_wr_resp,
  input  logic              inval_en,
  input  logic [IDX_W-1:0]  inval_idx,
  input  logic [QUAD_W-1:0] inval_quad,
  output logic [IDX_W-1:0]  look_idx,
  input  logic              look_valid,
  input  logic [QUAD_W-1:0] look_tag,
  input  logic [LINE_W-1:0] look_data,
  output logic              fill_en,
  output logic [QUAD_W-1:0] fill_tag,
  output logic              upd_en,
  output logic [WSEL_W-1:0] upd_sel,
  output logic [DATA_W-1:0] upd_word
);

  function automatic logic [QUAD_W-1:0] quad_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WSEL_W];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[WSEL_W +: IDX_W];
  endfunction

  function automatic logic [WSEL_W-1:0] sel_of(input logic [ADDR_W-1:0] a);
    return a[WSEL_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] pick_word(input logic [LINE_W-1:0] l,
                                                  input logic [WSEL_W-1:0] s);
    return l[s*DATA_W +: DATA_W];
  endfunction

  ctl_state_e        st_q, st_d;
  logic              rq_write_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [DATA_W-1:0] rq_wdata_q;
  logic              resp_valid_q;
  logic [DATA_W-1:0] resp_data_q;

  // named internal events
  logic rq_hit;
  logic accept_evt;
  logic read_hit_evt;
  logic recheck_evt;
  logic finish_rd;
  logic finish_wr;
  logic grant_evt;

  assign look_idx     = idx_of(rq_addr_q);
  assign rq_hit       = look_valid && (look_tag == quad_of(rq_addr_q));
  assign accept_evt   = (st_q == ST_IDLE) && cpu_req_valid;
  assign read_hit_evt = (st_q == ST_CHECK) && !rq_write_q && rq_hit;
  assign grant_evt    = (st_q == ST_WAIT_GNT) && bus_gnt;
  assign recheck_evt  = (st_q == ST_WAIT_GNT) && !bus_gnt && inval_en &&
                        (inval_idx == look_idx) && (inval_quad == quad_of(rq_addr_q));
  assign finish_rd    = (st_q == ST_WAIT_RESP) && !rq_write_q && own_rd_resp;
  assign finish_wr    = (st_q == ST_WAIT_RESP) && rq_write_q && own_wr_resp;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (cpu_req_valid) st_d = ST_CHECK;
      ST_CHECK:     st_d = read_hit_evt ? ST_IDLE : ST_WAIT_GNT;
      ST_WAIT_GNT: begin
        if (bus_gnt)          st_d = ST_WAIT_RESP;
        else if (recheck_evt) st_d = ST_CHECK;
      end
      ST_WAIT_RESP: if (finish_rd || finish_wr) st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      rq_write_q   <= 1'b0;
      rq_addr_q    <= '0;
      rq_wdata_q   <= '0;
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      st_q         <= st_d;
      resp_valid_q <= read_hit_evt || finish_rd || finish_wr;
      if (accept_evt) begin
        rq_write_q <= cpu_req_write;
        rq_addr_q  <= cpu_req_addr;
        rq_wdata_q <= cpu_req_wdata;
      end
      if (read_hit_evt)   resp_data_q <= pick_word(look_data, sel_of(rq_addr_q));
      else if (finish_rd) resp_data_q <= pick_word(bus_in_data, sel_of(rq_addr_q));
      else if (finish_wr) resp_data_q <= '0;
    end
  end

  assign cpu_busy       = (st_q != ST_IDLE);
  assign cpu_resp_valid = resp_valid_q;
  assign cpu_resp_rdata = resp_data_q;

  assign bus_req       = (st_q == ST_WAIT_GNT) || (st_q == ST_WAIT_RESP);
  assign bus_out_valid = grant_evt;
  assign bus_out_type  = rq_write_q ? 2'(PK_MEM_WR) : 2'(PK_MEM_RD);
  assign bus_out_addr  = rq_addr_q;
  assign bus_out_data  = rq_write_q ? rq_wdata_q : '0;
  assign bus_out_src   = SRC_W'(SRC_ID);

  assign fill_en  = finish_rd;
  assign fill_tag = quad_of(rq_addr_q);
  assign upd_en   = finish_wr && rq_hit;
  assign upd_sel  = sel_of(rq_addr_q);
  assign upd_word = rq_wdata_q;

  // R10: packets only under a grant
  a_r10_pkt_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> (bus_gnt && bus_req));

  // R10: ownership kept until own reply
  a_r10_hold_until_reply: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WAIT_RESP) && !own_rd_resp && !own_wr_resp) |=> bus_req);

  // R9: busy after acceptance
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> cpu_busy);

  // R9: response ends the busy period
  a_r9_resp_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |-> !cpu_busy);

  // R2: read hit answers with no bus activity
  a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    read_hit_evt |=> (cpu_resp_valid && !bus_req));

  // R8: recheck withdraws the bus request
  a_r8_recheck_drops: assert property (@(posedge clk) disable iff (!rst_n)
    recheck_evt |=> !bus_req);

endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int WORDS  = 4,
  parameter int LINES  = 8,
  parameter int SRC_W  = 3,
  parameter int SRC_ID = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  input  logic                    cpu_req_write,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  input  logic [DATA_W-1:0]       cpu_req_wdata,
  output logic                    cpu_busy,
  output logic                    cpu_resp_valid,
  output logic [DATA_W-1:0]       cpu_resp_rdata,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic                    bus_out_valid,
  output logic [1:0]              bus_out_type,
  output logic [ADDR_W-1:0]       bus_out_addr,
  output logic [DATA_W-1:0]       bus_out_data,
  output logic [SRC_W-1:0]        bus_out_src,
  input  logic                    bus_in_valid,
  input  logic [1:0]              bus_in_type,
  input  logic [ADDR_W-1:0]       bus_in_addr,
  input  logic [WORDS*DATA_W-1:0] bus_in_data,
  input  logic [SRC_W-1:0]        bus_in_src
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int QUAD_W = ADDR_W - WSEL_W;
  localparam int LINE_W = WORDS * DATA_W;

  logic [IDX_W-1:0]  look_idx, snp_idx;
  logic              look_valid, snp_valid;
  logic [QUAD_W-1:0] look_tag, snp_tag, snp_quad, fill_tag;
  logic [LINE_W-1:0] look_data;
  logic              fill_en, upd_en, inval_en, own_rd_resp, own_wr_resp;
  logic [WSEL_W-1:0] upd_sel;
  logic [DATA_W-1:0] upd_word;

  wtsc_store #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(QUAD_W),
    .IDX_W(IDX_W), .WSEL_W(WSEL_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .look_idx(look_idx), .look_valid(look_valid), .look_tag(look_tag), .look_data(look_data),
    .snp_idx(snp_idx), .snp_valid(snp_valid), .snp_tag(snp_tag),
    .fill_en(fill_en), .fill_idx(look_idx), .fill_tag(fill_tag), .fill_data(bus_in_data),
    .upd_en(upd_en), .upd_idx(look_idx), .upd_sel(upd_sel), .upd_word(upd_word),
    .inval_en(inval_en), .inval_idx(snp_idx)
  );

  wtsc_snoop #(
    .ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS), .SRC_W(SRC_W), .SRC_ID(SRC_ID),
    .IDX_W(IDX_W), .WSEL_W(WSEL_W), .QUAD_W(QUAD_W)
  ) u_snoop (
    .bus_in_valid(bus_in_valid), .bus_in_type(bus_in_type), .bus_in_addr(bus_in_addr),
    .bus_in_src(bus_in_src), .snp_valid(snp_valid), .snp_tag(snp_tag),
    .snp_idx(snp_idx), .snp_quad(snp_quad), .inval_en(inval_en),
    .own_rd_resp(own_rd_resp), .own_wr_resp(own_wr_resp)
  );

  wtsc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES), .SRC_W(SRC_W),
    .SRC_ID(SRC_ID), .IDX_W(IDX_W), .WSEL_W(WSEL_W), .QUAD_W(QUAD_W), .LINE_W(LINE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_busy(cpu_busy), .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_out_valid(bus_out_valid),
    .bus_out_type(bus_out_type), .bus_out_addr(bus_out_addr), .bus_out_data(bus_out_data),
    .bus_out_src(bus_out_src), .bus_in_data(bus_in_data),
    .own_rd_resp(own_rd_resp), .own_wr_resp(own_wr_resp),
    .inval_en(inval_en), .inval_idx(snp_idx), .inval_quad(snp_quad),
    .look_idx(look_idx), .look_valid(look_valid), .look_tag(look_tag), .look_data(look_data),
    .fill_en(fill_en), .fill_tag(fill_tag),
    .upd_en(upd_en), .upd_sel(upd_sel), .upd_word(upd_word)
  );

endmodule

// File: tb/wt_snoop_cache_bench.sv
module wt_snoop_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MY_ID = 2;
  localparam int OTHER_ID = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [11:0] cpu_req_addr = '0;
  logic [15:0] cpu_req_wdata = '0;
  logic        cpu_busy, cpu_resp_valid;
  logic [15:0] cpu_resp_rdata;
  logic        bus_req, bus_gnt = 1'b0, bus_out_valid;
  logic [1:0]  bus_out_type;
  logic [11:0] bus_out_addr;
  logic [15:0] bus_out_data;
  logic [2:0]  bus_out_src;
  logic        bus_in_valid = 1'b0;
  logic [1:0]  bus_in_type = '0;
  logic [11:0] bus_in_addr = '0;
  logic [63:0] bus_in_data = '0;
  logic [2:0]  bus_in_src = '0;

  wt_snoop_cache #(.SRC_ID(MY_ID)) u_wt_snoop_cache (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int  mem [4096];
  bit  mv [8];
  int  mt [8];
  int  checks = 0, errors = 0;
  bit  finished = 0;

  task automatic check(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] line_of(int q);
    logic [63:0] r;
    for (int w = 0; w < 4; w++) r[w*16 +: 16] = 16'(mem[q*4 + w]);
    return r;
  endfunction

  function automatic void model_snoop_write(int addr, int data);
    int i = (addr >> 2) % 8;
    mem[addr] = data & 16'hffff;
    if (mv[i] && mt[i] == (addr >> 2)) mv[i] = 0;
  endfunction

  // per-cycle protocol comparison against the bench view
  always @(negedge clk) if (rst_n && bus_out_valid) begin
    check(bus_gnt && bus_req, "R10", "packet without grant", 0, 1);
    check(bus_out_src == 3'(MY_ID), "R3", "packet source", bus_out_src, MY_ID);
  end
  always @(negedge clk) if (rst_n && cpu_resp_valid)
    check(!cpu_busy, "R9", "busy during response", cpu_busy, 0);

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) mv[i] = 0;
    @(negedge clk);
  endtask

  task automatic snoop(int typ, int addr, int data, int src);
    @(negedge clk);
    bus_in_valid = 1'b1; bus_in_type = 2'(typ); bus_in_addr = 12'(addr);
    bus_in_data = {4{16'(data)}}; bus_in_src = 3'(src);
    if (typ == 2 && src != MY_ID) model_snoop_write(addr, data);
    @(negedge clk);
    bus_in_valid = 1'b0;
  endtask

  task automatic do_req(bit wr, int addr, int wdata, int gdelay, int inj_at,
                        int inj_addr, int inj_data, bit decoy, string rq);
    int  idx = (addr >> 2) % 8;
    int  quad = addr >> 2;
    bit  exp_hit = mv[idx] && mt[idx] == quad;
    int  exp_pkts = (!wr && exp_hit) ? 0 : 1;
    int  pkts = 0, ptype = 0, paddr = 0, pdata = 0, phase = 0;
    bit  got = 0, seen = 0, dropped = 0, hold_ok = 1, req_at = 0, busy_at = 0;
    int  rdata = 0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = 12'(addr); cpu_req_wdata = 16'(wdata);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    check(cpu_busy, "R9", "busy after accept", cpu_busy, 1);
    for (int k = 0; k < 60 && !got; k++) begin
      bus_in_valid = 1'b0; bus_gnt = 1'b0;
      if (cpu_resp_valid) begin
        got = 1; rdata = cpu_resp_rdata; req_at = bus_req; busy_at = cpu_busy;
      end else begin
        if (phase == 0 && bus_req) seen = 1;
        if (phase == 0 && seen && !bus_req) dropped = 1;
        if (inj_at >= 0 && k == inj_at) begin
          bus_in_valid = 1'b1; bus_in_type = 2'd2; bus_in_addr = 12'(inj_addr);
          bus_in_data = {4{16'(inj_data)}}; bus_in_src = 3'(OTHER_ID);
          model_snoop_write(inj_addr, inj_data);
        end else if (phase == 0 && bus_req && k >= gdelay) begin
          bus_gnt = 1'b1;
          #1;
          if (bus_out_valid) begin
            pkts++; ptype = bus_out_type; paddr = bus_out_addr; pdata = bus_out_data;
            if (ptype == 2) mem[paddr] = pdata;
          end
          phase = 1;
        end else if (phase == 1 || phase == 2) begin
          if (!bus_req) hold_ok = 0;
          bus_in_valid = 1'b1; bus_in_addr = 12'(addr);
          bus_in_type = wr ? 2'd3 : 2'd1;
          if (decoy && phase == 1) begin
            bus_in_src = 3'(OTHER_ID); bus_in_data = 64'hdead_beef_cafe_f00d; phase = 2;
          end else begin
            bus_in_src = 3'(MY_ID); bus_in_data = line_of(quad); phase = 3;
          end
        end
        @(negedge clk);
      end
    end
    bus_in_valid = 1'b0; bus_gnt = 1'b0;
    check(got, rq, "response seen", got, 1);
    check(phase == (exp_pkts ? 3 : 0), "R7", "response only after own reply", phase, exp_pkts ? 3 : 0);
    check(pkts == exp_pkts, rq, "bus packets", pkts, exp_pkts);
    if (pkts > 0) begin
      check(ptype == (wr ? 2 : 0), rq, "packet type", ptype, wr ? 2 : 0);
      check(paddr == addr, rq, "packet addr", paddr, addr);
      if (wr) check(pdata == (wdata & 16'hffff), "R4", "write word", pdata, wdata & 16'hffff);
    end
    if (!wr) check(rdata == mem[addr], rq, "read data", rdata, mem[addr]);
    check(!req_at, "R10", "bus_req dropped after reply", req_at, 0);
    check(!busy_at, "R9", "idle at response", busy_at, 0);
    check(hold_ok, "R10", "bus_req held until reply", hold_ok, 1);
    if (inj_at >= 0) check(dropped, "R8", "request withdrawn on recheck", dropped, 1);
    if (!wr && !exp_hit) begin mv[idx] = 1; mt[idx] = quad; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = (i * 37 + 11) & 16'hffff;
    do_reset();
    // R11: reset state
    check(!cpu_busy && !bus_req && !cpu_resp_valid && !bus_out_valid, "R11",
          "reset outputs", {cpu_busy, bus_req, cpu_resp_valid}, 0);
    do_req(0, 'h045, 0, 2, -1, 0, 0, 1, "R3");       // miss, decoy reply (R7)
    do_req(0, 'h046, 0, 0, -1, 0, 0, 0, "R2");       // same line hit
    do_req(0, 'h064, 0, 1, -1, 0, 0, 0, "R1");       // same index, other tag
    do_req(0, 'h045, 0, 0, -1, 0, 0, 0, "R1");       // evicted, misses again
    do_req(1, 'h047, 'hbeef, 3, -1, 0, 0, 1, "R4");  // write hit
    do_req(0, 'h047, 0, 0, -1, 0, 0, 0, "R5");       // updated in place
    do_req(1, 'h100, 'h1234, 0, -1, 0, 0, 0, "R4");  // write miss
    do_req(0, 'h100, 0, 0, -1, 0, 0, 0, "R5");       // not allocated: miss
    do_req(1, 'h120, 'h5555, 0, -1, 0, 0, 0, "R5");  // miss on other tag of index 0
    do_req(0, 'h101, 0, 0, -1, 0, 0, 0, "R5");       // line kept: hit
    snoop(2, 'h102, 'h7777, OTHER_ID);              // R6 foreign write invalidates
    do_req(0, 'h101, 0, 0, -1, 0, 0, 0, "R6");
    snoop(0, 'h101, 0, OTHER_ID);                   // R6 foreign read: no effect
    snoop(2, 'h101, mem['h101], MY_ID);             // R6 own source: no effect
    snoop(2, 'h121, 'h4444, OTHER_ID);              // R6 other tag: no effect
    do_req(0, 'h102, 0, 0, -1, 0, 0, 0, "R6");
    // R8: invalidation while waiting for grant
    do_req(0, 'h200, 0, 0, -1, 0, 0, 0, "R3");
    do_req(1, 'h201, 'habcd, 6, 2, 'h203, 'h9999, 0, "R8");
    do_req(0, 'h201, 0, 0, -1, 0, 0, 0, "R8");
    do_req(0, 'h203, 0, 0, -1, 0, 0, 0, "R8");
    // R11: reset clears lines
    do_reset();
    do_req(0, 'h200, 0, 0, -1, 0, 0, 0, "R11");
    // sweep: miss then hit on many lines
    for (int a = 0; a < 12; a++) begin
      do_req(0, 'h300 + a * 5, 0, a % 3, -1, 0, 0, a[0], "R3");
      do_req(0, 'h300 + a * 5, 0, 0, -1, 0, 0, 0, "R2");
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule